// File: doc/BRIEF.md
# USB Host Interrupt Flag and Enable Unit

This block gathers six host-controller events into sticky status flags and turns them into one interrupt line. The events are a scheduling overrun, completion of a done-queue writeback, start of frame, detected resume signalling, a frame-number overflow and a root-hub change. Each flag is set by a one-cycle hardware pulse (or, for overflow, by a change of the frame number's top bit) and is cleared by software writing 1 to it.

The enable mask has no plain read/write address. Software sets enable bits by writing ones to one address and clears them by writing ones to another. Both addresses read back the current mask. A master bit at position 31 gates every source. A two-bit overrun counter in the command/status word counts every overrun event, including those that arrive while the overrun flag is already set. The unit also holds off done-queue writebacks: a new writeback completes only once software has acknowledged the previous one.

The register port is a flat 32-bit interface with one write strobe and a combinational read. Offsets: 0x08 command/status, 0x0C status flags, 0x10 enable-set, 0x14 enable-clear.

Top module: `hcirq_ctrl`

## Requirements
- R1: A write to offset 0x10 sets every enable bit written as 1, at positions 0, 1, 2, 3, 5, 6 and 31 (master); bits written as 0 keep their value.
- R2: A write to offset 0x14 clears every enable bit written as 1; bits written as 0 keep their value. Reads at 0x10 and at 0x14 both return the current enable mask.
- R3: `irq_out` is high exactly when the master enable is set and at least one status flag is set whose enable bit is also set.
- R4: Status flags read at offset 0x0C with the layout overrun=bit 0, writeback done=bit 1, start of frame=bit 2, resume=bit 3, frame overflow=bit 5, root-hub change=bit 6. Writing 1 to a flag clears it. Writing 0 leaves it unchanged.
- R5: A hardware set and a software clear of the same flag in the same cycle leave the flag set.
- R6: The overrun counter reads at bits 17:16 of offset 0x08. It is 0 after reset, adds 1 per overrun pulse, wraps from 3 to 0, and counts even while the overrun flag is already set.
- R7: `wb_done` is high in a cycle where `wb_req` is high and the writeback-done flag is clear. Each completion sets that flag, so no further writeback completes until software clears it.
- R8: The frame-overflow flag sets one cycle after `frame_msb` changes, on a rise and on a fall alike.
- R9: Reset clears all enables, flags and the counter. Unused bit positions and unmapped offsets read 0, and writes to them have no effect.
- R10: An overrun, start-of-frame, resume or root-hub pulse sets its flag on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte offset of register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ev_sched_ovr | input | 1 | Scheduling overrun pulse |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_resume | input | 1 | Resume detected pulse |
| ev_rh_change | input | 1 | Root-hub status change pulse |
| frame_msb | input | 1 | Top bit of the frame number |
| wb_req | input | 1 | Done-queue writeback request (level) |
| wb_done | output | 1 | Writeback completes this cycle |
| irq_out | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is a hardware set that lands in the same cycle as a software clear of the same flag. The bench reaches it by asserting the event pulse in the same cycle as the status write. The writeback hold-off is also hard to reach, because it needs a request held across a flag acknowledgement. The bench keeps `wb_req` high through a clear and checks `wb_done` in each cycle around it. The interrupt function is swept over every combination of six flags against six enables plus master. The flags are built up each time from real event pulses, so the overrun counter's wrap is checked many times along the way.

// File: rtl/hcirq_pkg.sv
package hcirq_pkg;
  localparam int DATA_W   = 32;
  localparam int SRC_W    = 7;
  localparam int BIT_SO   = 0;
  localparam int BIT_WDH  = 1;
  localparam int BIT_SF   = 2;
  localparam int BIT_RD   = 3;
  localparam int BIT_FNO  = 5;
  localparam int BIT_RHSC = 6;
  localparam int BIT_MSTR = 31;
  localparam int CNT_LSB  = 16;
  localparam logic [SRC_W-1:0] SRC_KEEP = 7'b110_1111;

  localparam logic [7:0] OFF_CMDSTAT = 8'h08;
  localparam logic [7:0] OFF_STATUS  = 8'h0C;
  localparam logic [7:0] OFF_IEN_SET = 8'h10;
  localparam logic [7:0] OFF_IEN_CLR = 8'h14;

  function automatic logic irq_eval(input logic [SRC_W-1:0] flags,
                                    input logic [SRC_W-1:0] en,
                                    input logic master);
    return master && ((flags & en) != '0);
  endfunction

  function automatic logic [SRC_W-1:0] apply_set_clr(input logic [SRC_W-1:0] cur,
                                                     input logic [SRC_W-1:0] setv,
                                                     input logic [SRC_W-1:0] clrv);
    return (cur & ~clrv) | setv;
  endfunction
endpackage

// File: rtl/hcirq_enable.sv
module hcirq_enable
  import hcirq_pkg::*;
#(
  parameter int W = SRC_W,
  parameter logic [W-1:0] KEEP = SRC_KEEP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  input  logic         wmaster,
  output logic [W-1:0] en_o,
  output logic         master_o
);
  logic [W-1:0] en_q;
  logic         master_q;
  logic [W-1:0] set_v, clr_v;

  assign set_v = set_we ? (wbits & KEEP) : '0;
  assign clr_v = clr_we ? (wbits & KEEP) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      en_q <= apply_set_clr(en_q, set_v, clr_v);
      if (set_we && wmaster)      master_q <= 1'b1;
      else if (clr_we && wmaster) master_q <= 1'b0;
    end
  end

  assign en_o     = en_q;
  assign master_o = master_q;

  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en_q & $past(wbits & KEEP)) == $past(wbits & KEEP))); // R1
  AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(wbits)) == '0)); // R2
  AST_EN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> ($stable(en_q) && $stable(master_q))); // R2
  AST_EN_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & ~KEEP) == '0)); // R9
endmodule

// File: rtl/hcirq_status.sv
module hcirq_status
  import hcirq_pkg::*;
#(
  parameter int W = SRC_W,
  parameter logic [W-1:0] KEEP = SRC_KEEP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_set,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] clr_v, set_v;

  assign clr_v = clr_we ? (wbits & KEEP) : '0;
  assign set_v = hw_set & KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= apply_set_clr(flags_q, set_v, clr_v);
  end

  assign flags_o = flags_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((flags_q & $past(set_v)) == $past(set_v))); // R5
  AST_CLR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && hw_set == '0) |=> (flags_q == ($past(flags_q) & ~$past(wbits & KEEP)))); // R4
endmodule

// File: rtl/hcirq_ovr_ctr.sv
module hcirq_ovr_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt_q == CNT_W'($past(cnt_q) + 1))); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/hcirq_ctrl.sv
module hcirq_ctrl
  import hcirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_sched_ovr,
  input  logic              ev_sof,
  input  logic              ev_resume,
  input  logic              ev_rh_change,
  input  logic              frame_msb,
  input  logic              wb_req,
  output logic              wb_done,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMDSTAT);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_IEN_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_IEN_CLR);

  logic             sel_sts, sel_set, sel_clr, sel_cmd;
  logic             sts_we, set_we, clr_we;
  logic [SRC_W-1:0] hw_set, flags, en;
  logic             master;
  logic [CNT_W-1:0] ovr_cnt;
  logic             msb_q, fno_evt, wb_fire;
  logic             unused_wdata;

  assign sel_sts = (reg_addr == A_STS);
  assign sel_set = (reg_addr == A_SET);
  assign sel_clr = (reg_addr == A_CLR);
  assign sel_cmd = (reg_addr == A_CMD);
  assign sts_we  = reg_wr && sel_sts;
  assign set_we  = reg_wr && sel_set;
  assign clr_we  = reg_wr && sel_clr;
  assign unused_wdata = ^reg_wdata[BIT_MSTR-1:SRC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) msb_q <= 1'b0;
    else        msb_q <= frame_msb;
  end
  assign fno_evt = (frame_msb != msb_q);
  assign wb_fire = wb_req && !flags[BIT_WDH];

  always_comb begin
    hw_set           = '0;
    hw_set[BIT_SO]   = ev_sched_ovr;
    hw_set[BIT_WDH]  = wb_fire;
    hw_set[BIT_SF]   = ev_sof;
    hw_set[BIT_RD]   = ev_resume;
    hw_set[BIT_FNO]  = fno_evt;
    hw_set[BIT_RHSC] = ev_rh_change;
  end

  hcirq_status #(.W(SRC_W), .KEEP(SRC_KEEP)) u_status (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .clr_we(sts_we),
    .wbits(reg_wdata[SRC_W-1:0]), .flags_o(flags));

  hcirq_enable #(.W(SRC_W), .KEEP(SRC_KEEP)) u_enable (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .wbits(reg_wdata[SRC_W-1:0]), .wmaster(reg_wdata[BIT_MSTR]),
    .en_o(en), .master_o(master));

  hcirq_ovr_ctr #(.CNT_W(CNT_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .inc(ev_sched_ovr), .cnt_o(ovr_cnt));

  always_comb begin
    reg_rdata = '0;
    if (sel_sts)              reg_rdata = DATA_W'(flags);
    else if (sel_set || sel_clr) begin
      reg_rdata           = DATA_W'(en);
      reg_rdata[BIT_MSTR] = master;
    end else if (sel_cmd)     reg_rdata = DATA_W'(ovr_cnt) << CNT_LSB;
  end

  assign wb_done = wb_fire;
  assign irq_out = irq_eval(flags, en, master);

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> master); // R3
  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((flags & en) != '0)); // R3
  AST_WB_LATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> flags[BIT_WDH]); // R7
  AST_WB_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done && !sts_we) |=> !wb_done); // R7
  AST_FNO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_msb != $past(frame_msb)) |=> flags[BIT_FNO]); // R8
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> flags[BIT_SF]); // R10
endmodule

// File: tb/sim_hcirq_ctrl.sv
module sim_hcirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_sched_ovr = 0, ev_sof = 0, ev_resume = 0, ev_rh_change = 0;
  logic frame_msb = 0, wb_req = 0;
  logic wb_done, irq_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [31:0] ENMASK = 32'h8000_006F;
  localparam int POS [6] = '{0, 1, 2, 3, 5, 6};

  always #4 clk = ~clk;

  hcirq_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_sched_ovr(ev_sched_ovr),
    .ev_sof(ev_sof), .ev_resume(ev_resume), .ev_rh_change(ev_rh_change),
    .frame_msb(frame_msb), .wb_req(wb_req), .wb_done(wb_done), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  function automatic logic [31:0] flagmap(input logic [5:0] f);
    logic [31:0] r = '0;
    for (int i = 0; i < 6; i++) r[POS[i]] = f[i];
    return r;
  endfunction

  initial begin : main
    logic [31:0] d, en_m, lcg;
    logic [1:0]  cnt_m;
    logic        fm;
    cnt_m = 0; fm = 0; en_m = 0; lcg = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R9 reset state and unmapped reads
    rd(8'h08, d); chk("R9 cmd reset", d, 0);
    rd(8'h0C, d); chk("R9 status reset", d, 0);
    rd(8'h10, d); chk("R9 enable reset", d, 0);
    rd(8'h14, d); chk("R9 disable reset", d, 0);
    chk("R9 irq reset", {31'b0, irq_out}, 0);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R9 unmapped read", d, 0);
    rd(8'h10, d); chk("R9 unmapped write no effect", d, 0);

    // R1 R2 set/clear sweep
    for (int k = 0; k < 48; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (k[0] == 1'b0 || k % 5 == 0) begin
        wr(8'h10, lcg); en_m = en_m | (lcg & ENMASK);
      end else begin
        wr(8'h14, lcg); en_m = en_m & ~(lcg & ENMASK);
      end
      rd(8'h10, d); chk("R1 mask via set address", d, en_m);
      rd(8'h14, d); chk("R2 mask via clear address", d, en_m);
    end
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R2 clear all", d, 0);

    // R3 R4 R6 R8 R10 exhaustive flags x enables
    for (int e = 0; e < 128; e++) begin
      for (int f = 0; f < 64; f++) begin
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h10, {e[6], 24'b0, flagmap(e[5:0])[6:0]});
        @(negedge clk);
        ev_sched_ovr = f[0]; wb_req = f[1]; ev_sof = f[2]; ev_resume = f[3];
        if (f[4]) begin fm = ~fm; frame_msb = fm; end
        ev_rh_change = f[5];
        @(posedge clk); @(negedge clk);
        ev_sched_ovr = 0; wb_req = 0; ev_sof = 0; ev_resume = 0; ev_rh_change = 0;
        if (f[0]) cnt_m = cnt_m + 2'd1;
        rd(8'h0C, d); chk("R10 R8 R4 flags from events", d, flagmap(f[5:0]));
        chk("R3 irq", {31'b0, irq_out},
            {31'b0, e[6] && ((f[5:0] & e[5:0]) != 0)});
        rd(8'h08, d); chk("R6 counter wrap", d, {14'b0, cnt_m, 16'b0});
        wr(8'h0C, 32'hFFFF_FFFF);
        chk("R3 irq after clear", {31'b0, irq_out}, 0);
      end
    end

    // R4 write 0 no effect, single bit clear
    @(negedge clk); ev_sof = 1; ev_resume = 1; ev_rh_change = 1;
    @(posedge clk); @(negedge clk); ev_sof = 0; ev_resume = 0; ev_rh_change = 0;
    wr(8'h0C, 32'h0);
    rd(8'h0C, d); chk("R4 zero write keeps flags", d, 32'h4C);
    wr(8'h0C, 32'h0000_0008);
    rd(8'h0C, d); chk("R4 one-bit clear", d, 32'h44);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R5 set wins over same-cycle clear
    @(negedge clk); reg_addr = 8'h0C; reg_wdata = 32'h4; reg_wr = 1; ev_sof = 1;
    @(posedge clk); @(negedge clk); reg_wr = 0; ev_sof = 0;
    rd(8'h0C, d); chk("R5 set beats clear", d, 32'h4);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R6 counting while flag already set
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ev_sched_ovr = 1;
      @(posedge clk); @(negedge clk); ev_sched_ovr = 0;
      cnt_m = cnt_m + 2'd1;
      rd(8'h08, d); chk("R6 count with flag set", d, {14'b0, cnt_m, 16'b0});
    end
    rd(8'h0C, d); chk("R6 flag stays", d, 32'h1);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R7 writeback hold-off with request held
    @(negedge clk); wb_req = 1; #1;
    chk("R7 first writeback", {31'b0, wb_done}, 1);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk); #1;
      chk("R7 held off", {31'b0, wb_done}, 0);
    end
    reg_addr = 8'h0C; reg_wdata = 32'h2; reg_wr = 1; #1;
    chk("R7 held during clear", {31'b0, wb_done}, 0);
    @(posedge clk); @(negedge clk); reg_wr = 0; #1;
    chk("R7 resumes after clear", {31'b0, wb_done}, 1);
    @(posedge clk); @(negedge clk); wb_req = 0; #1;
    chk("R7 single completion", {31'b0, wb_done}, 0);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R8 both directions, stable does nothing
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); fm = ~fm; frame_msb = fm;
      @(posedge clk); @(negedge clk);
      rd(8'h0C, d); chk("R8 msb edge", d, 32'h20);
      wr(8'h0C, 32'h20);
      repeat (3) @(posedge clk); @(negedge clk);
      rd(8'h0C, d); chk("R8 stable msb", d, 32'h0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule